// File: doc/BRIEF.md
# Virtually indexed, physically tagged direct-mapped cache

This block is a 4 KB direct-mapped cache of 1024 one-word entries that sits beside a TLB on the load/store path. Its index comes only from the page-offset part of the virtual address. The array read therefore starts in the same cycle as the TLB lookup, and it does not have to wait for the translated address. Each entry stores the physical frame number it was filled from. A lookup is a hit only when the TLB reports a valid translation and the stored frame equals the frame number the TLB returns.

The CPU side issues word reads and byte-masked writes and holds the request until the cache answers with a ready strobe. A read hit completes in the cycle it is presented. A read miss fetches one word from memory and installs it. Writes always go through to memory. A write updates the cached copy only on a hit and never allocates an entry. When the TLB cannot translate, the access waits and the cache state does not change. The cache size equals the page size by construction: the index width is the page-offset width less the byte-offset width.

Top module: `vipt_cache`

## Requirements
- R1: After reset every entry is invalid, so `cpu_ready` and `mem_req` are low, and the first read of any address is a miss.
- R2: The byte offset is `cpu_vaddr[1:0]` and is ignored, so any two addresses in the same word return that word. The index is `cpu_vaddr[11:2]`. `tlb_vpn` always equals `cpu_vaddr[31:12]`.
- R3: A read is a hit when `tlb_hit` is high, the indexed entry is valid, and its stored frame equals `tlb_pfn`. On a hit, `cpu_ready` rises in the same cycle with the cached word and no memory request is made.
- R4: While `cpu_req` is high and `tlb_hit` is low, `cpu_ready` and `mem_req` stay low and no entry changes. After translation arrives, the access behaves as if it had not stalled.
- R5: A read miss raises `mem_req` with `mem_we` low at `mem_addr = {tlb_pfn, cpu_vaddr[11:2], 2'b00}`. In the cycle `mem_ack` is high, `cpu_ready` is high and `cpu_rdata` equals `mem_rdata`, and the entry is installed as valid with that frame.
- R6: Every write is sent to memory with `mem_we` high, the physical word address of R5, `mem_wdata = cpu_wdata` and `mem_be = cpu_be`, and it completes with `cpu_ready` at `mem_ack`. Bit i of the byte enable selects bits 8i+7:8i. A write hit merges the enabled bytes into the cached word. A write miss allocates nothing, so a following read of that word misses.
- R7: Two virtual pages translated to the same frame hit the same entry. The same virtual page translated to a different frame misses.
- R8: A read miss replaces whatever frame the indexed entry held before, so a later access to the old frame at that index misses.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R10: `cpu_ready` is high only while `cpu_req` is high. The CPU holds its request unchanged until `cpu_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_vaddr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready on reads |
| tlb_vpn | output | 20 | Virtual page number presented to the TLB |
| tlb_hit | input | 1 | TLB holds a translation for tlb_vpn |
| tlb_pfn | input | 20 | Translated physical frame number |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Physical word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
Reads are driven against a bench model of valid bits and stored frames. The model predicts hit or miss, and the bench checks it through the completion latency and whether a memory request appeared. Targeted patterns separate the cases that share an index: synonyms through different virtual pages, one virtual page remapped to a new frame, and eviction by a conflicting frame. Partial-mask write hits and write misses tell write-through with merge apart from write allocation. A stalled translation tests that the lookup is deferred rather than dropped. A randomized mix over a few indices and frames then exercises all of these against a reference memory.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  parameter int unsigned ADDR_W    = 32;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned PAGE_BITS = 12;

  localparam int unsigned BYTES   = DATA_W / 8;
  localparam int unsigned OFF_W   = $clog2(BYTES);
  localparam int unsigned IDX_W   = PAGE_BITS - OFF_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS;

  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [BYTES-1:0]   be_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
  import vipt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  idx_t   rd_idx,
  output logic   rd_valid,
  output frame_t rd_frame,
  input  logic   wr_en,
  input  idx_t   wr_idx,
  input  frame_t wr_frame
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  frame_t             frame_q [ENTRIES];

  // next-state for the valid vector
  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // frame array carries no reset; its valid bit gates its use
  always_ff @(posedge clk) begin
    if (wr_en) frame_q[wr_idx] <= wr_frame;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_frame = frame_q[rd_idx];

  // R5: an install leaves the written entry valid with the supplied frame
  p_install_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && (frame_q[$past(wr_idx)] == $past(wr_frame))));

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
  import vipt_pkg::*;
(
  input  logic  clk,
  input  idx_t  rd_idx,
  output word_t rd_word,
  input  logic  wr_en,
  input  idx_t  wr_idx,
  input  be_t   wr_be,
  input  word_t wr_data
);

  // one independent byte-wide array per lane so masked writes stay per-lane
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lane_q [ENTRIES];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_q[wr_idx] <= wr_data[8*b +: 8];
    end

    assign rd_word[8*b +: 8] = lane_q[rd_idx];
  end

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  idx_t              cpu_idx,
  input  word_t             cpu_wdata,
  input  be_t               cpu_be,
  input  logic              tlb_hit,
  input  frame_t            tlb_pfn,
  input  logic              lk_valid,
  input  frame_t            lk_frame,
  input  word_t             lk_word,
  output logic              cpu_ready,
  output word_t             cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output word_t             mem_wdata,
  output be_t               mem_be,
  input  logic              mem_ack,
  input  word_t             mem_rdata,
  output logic              tag_wr_en,
  output idx_t              tag_wr_idx,
  output frame_t            tag_wr_frame,
  output logic              dat_wr_en,
  output idx_t              dat_wr_idx,
  output be_t               dat_wr_be,
  output word_t             dat_wr_data
);

  st_e    st_q, st_d;
  idx_t   idx_q;
  frame_t frame_q;
  word_t  wdata_q;
  be_t    be_q;
  logic   hit_q;

  logic lookup_ok;
  logic tag_match;
  logic cap_en;

  // lookup runs in the request cycle, in parallel with translation
  assign lookup_ok = (st_q == ST_IDLE) && cpu_req && tlb_hit;
  assign tag_match = lk_valid && (lk_frame == tlb_pfn);
  assign cap_en    = lookup_ok && (cpu_we || !tag_match);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (cap_en) st_d = cpu_we ? ST_WRITE : ST_FILL;
      ST_FILL:  if (mem_ack) st_d = ST_IDLE;
      ST_WRITE: if (mem_ack) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // request capture, clock-enabled by cap_en
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      frame_q <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      hit_q   <= 1'b0;
    end else if (cap_en) begin
      idx_q   <= cpu_idx;
      frame_q <= tlb_pfn;
      wdata_q <= cpu_wdata;
      be_q    <= cpu_be;
      hit_q   <= tag_match;
    end
  end

  always_comb begin
    cpu_ready   = 1'b0;
    cpu_rdata   = lk_word;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    tag_wr_en   = 1'b0;
    dat_wr_en   = 1'b0;
    dat_wr_be   = be_q;
    dat_wr_data = wdata_q;
    unique case (st_q)
      ST_IDLE: cpu_ready = lookup_ok && !cpu_we && tag_match;
      ST_FILL: begin
        mem_req     = 1'b1;
        cpu_ready   = mem_ack;
        cpu_rdata   = mem_rdata;
        tag_wr_en   = mem_ack;
        dat_wr_en   = mem_ack;
        dat_wr_be   = '1;
        dat_wr_data = mem_rdata;
      end
      ST_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        cpu_ready = mem_ack;
        dat_wr_en = mem_ack && hit_q;
      end
      default: ;
    endcase
  end

  assign mem_addr     = {frame_q, idx_q, {OFF_W{1'b0}}};
  assign mem_wdata    = wdata_q;
  assign mem_be       = be_q;
  assign tag_wr_idx   = idx_q;
  assign tag_wr_frame = frame_q;
  assign dat_wr_idx   = idx_q;

  // R4: an untranslated request leaves the controller idle with no memory traffic
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cpu_req && !tlb_hit) |=> (st_q == ST_IDLE && !mem_req));

  // R9: an outstanding memory request does not move until acknowledged
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: completion only answers a live request
  p_ready_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_vaddr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [BYTES-1:0]    cpu_be,
  output logic                cpu_ready,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic [FRAME_W-1:0]  tlb_vpn,
  input  logic                tlb_hit,
  input  logic [FRAME_W-1:0]  tlb_pfn,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [BYTES-1:0]    mem_be,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata
);

  idx_t   cpu_idx;
  logic   unused_off;
  logic   lk_valid;
  frame_t lk_frame;
  word_t  lk_word;
  logic   tag_wr_en;
  idx_t   tag_wr_idx;
  frame_t tag_wr_frame;
  logic   dat_wr_en;
  idx_t   dat_wr_idx;
  be_t    dat_wr_be;
  word_t  dat_wr_data;

  // index from page-offset bits only; page number goes to the TLB untouched
  assign cpu_idx    = cpu_vaddr[PAGE_BITS-1:OFF_W];
  assign tlb_vpn    = cpu_vaddr[ADDR_W-1:PAGE_BITS];
  assign unused_off = ^cpu_vaddr[OFF_W-1:0];

  vipt_tag_store u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (cpu_idx),
    .rd_valid (lk_valid),
    .rd_frame (lk_frame),
    .wr_en    (tag_wr_en),
    .wr_idx   (tag_wr_idx),
    .wr_frame (tag_wr_frame)
  );

  vipt_data_store u_data (
    .clk     (clk),
    .rd_idx  (cpu_idx),
    .rd_word (lk_word),
    .wr_en   (dat_wr_en),
    .wr_idx  (dat_wr_idx),
    .wr_be   (dat_wr_be),
    .wr_data (dat_wr_data)
  );

  vipt_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_idx      (cpu_idx),
    .cpu_wdata    (cpu_wdata),
    .cpu_be       (cpu_be),
    .tlb_hit      (tlb_hit),
    .tlb_pfn      (tlb_pfn),
    .lk_valid     (lk_valid),
    .lk_frame     (lk_frame),
    .lk_word      (lk_word),
    .cpu_ready    (cpu_ready),
    .cpu_rdata    (cpu_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_be       (mem_be),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .tag_wr_en    (tag_wr_en),
    .tag_wr_idx   (tag_wr_idx),
    .tag_wr_frame (tag_wr_frame),
    .dat_wr_en    (dat_wr_en),
    .dat_wr_idx   (dat_wr_idx),
    .dat_wr_be    (dat_wr_be),
    .dat_wr_data  (dat_wr_data)
  );

  // R6: a write never installs a tag (no allocate on write)
  p_no_write_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !tag_wr_en);

endmodule

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_vaddr, cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic [19:0] tlb_vpn;
  logic        tlb_hit;
  logic [19:0] tlb_pfn;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  vipt_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_vaddr(cpu_vaddr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] phys_mem [logic [31:0]];
  logic [31:0] ref_mem  [logic [31:0]];
  bit          m_valid  [int];
  logic [19:0] m_frame  [int];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  logic [31:0] last_addr, last_wdata;
  logic        last_we;
  logic [3:0]  last_be;
  int          mem_ops = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] phys_get(input logic [31:0] a);
    return phys_mem.exists(a) ? phys_mem[a] : seed_word(a);
  endfunction

  function automatic logic [31:0] ref_get(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
  endfunction

  // memory model: fixed latency, checks the request is held (R9)
  initial begin
    int          cnt;
    logic [31:0] hold_a;
    logic        hold_we;
    cnt = 0; hold_a = '0; hold_we = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        if (cnt == 0) begin
          hold_a = mem_addr; hold_we = mem_we;
        end else begin
          chk(mem_addr == hold_a && mem_we == hold_we, "R9", mem_addr, hold_a, "memory request held");
        end
        cnt++;
        if (cnt == LAT) begin
          cnt = 0;
          mem_ack   = 1'b1;
          mem_rdata = phys_get(mem_addr);
          if (mem_we) phys_mem[mem_addr] = merge(phys_get(mem_addr), mem_wdata, mem_be);
          last_addr = mem_addr; last_we = mem_we; last_wdata = mem_wdata; last_be = mem_be;
          mem_ops++;
        end
      end
    end
  end

  // monitor: pops expected read data as completions appear
  initial begin
    logic [31:0] e;
    string       t;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", cpu_rdata, '0, "read completion with nothing expected");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cpu_rdata == e, t, cpu_rdata, e, "read data");
        end
      end
    end
  end

  // driver: one access, with optional translation stall
  task automatic access(input bit we, input logic [31:0] va, input logic [19:0] pfn,
                        input logic [31:0] wd, input logic [3:0] be, input int stall,
                        input string req_in);
    int          idx;
    bit          hit;
    int          cyc;
    bit          seen;
    int          ops0;
    string       req;
    logic [31:0] pa;
    idx  = int'(va[11:2]);
    pa   = {pfn, va[11:2], 2'b00};
    hit  = m_valid.exists(idx) && m_valid[idx] && (m_frame[idx] == pfn);
    req  = (req_in == "") ? (we ? "R6" : (hit ? "R3" : "R5")) : req_in;
    cyc  = 0;
    seen = 1'b0;
    if (!we) begin
      exp_q.push_back(ref_get(pa));
      tag_q.push_back(req);
    end
    cpu_req = 1'b1; cpu_we = we; cpu_vaddr = va; cpu_wdata = wd; cpu_be = be;
    tlb_hit = 1'b0; tlb_pfn = ~pfn;
    for (int s = 0; s < stall; s++) begin
      #1;
      chk(!cpu_ready && !mem_req, "R4", {30'd0, cpu_ready, mem_req}, '0, "stall outputs");
      @(negedge clk);
    end
    tlb_hit = 1'b1; tlb_pfn = pfn;
    ops0 = mem_ops;
    #1;
    chk(tlb_vpn == va[31:12], "R2", {12'd0, tlb_vpn}, {12'd0, va[31:12]}, "page number to TLB");
    forever begin
      if (mem_req) seen = 1'b1;
      if (cpu_ready || cyc > 50) break;
      @(negedge clk);
      #1;
      cyc++;
    end
    if (!we && hit) begin
      chk(cyc == 0 && !seen, req, cyc, 0, "hit completes in request cycle");
    end else begin
      chk(cyc >= 1 && mem_ops == ops0 + 1, req, cyc, LAT, "miss or write goes to memory");
      chk(last_addr == pa && last_we == we, req, last_addr, pa, "memory address");
      if (we) chk(last_wdata == wd && last_be == be, req, last_wdata, wd, "memory write data");
    end
    if (!we) begin
      m_valid[idx] = 1'b1;
      m_frame[idx] = pfn;
    end else begin
      ref_mem[pa] = merge(ref_get(pa), wd, be);
    end
    @(negedge clk);
    cpu_req = 1'b0; tlb_hit = 1'b0;
  endtask

  task automatic idle_check();
    #1;
    chk(!cpu_ready, "R10", {31'd0, cpu_ready}, '0, "no ready without request");
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_vaddr = '0; cpu_wdata = '0; cpu_be = '0;
    tlb_hit = 1'b0; tlb_pfn = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_ready && !mem_req, "R1", {30'd0, cpu_ready, mem_req}, '0, "reset outputs");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    access(1'b0, 32'h0000_1010, 20'h00AB5, '0, '0, 0, "R1");   // cold miss
    idle_check();
    access(1'b0, 32'h0000_1010, 20'h00AB5, '0, '0, 0, "R3");   // hit
    access(1'b0, 32'h0000_1013, 20'h00AB5, '0, '0, 0, "R2");   // byte offset ignored
    access(1'b0, 32'h0000_1010, 20'h00AB5, '0, '0, 3, "R4");   // stalled, still hits
    access(1'b1, 32'h0000_1010, 20'h00AB5, 32'hDEAD_BEEF, 4'hF, 0, "R6");
    access(1'b0, 32'h0000_1010, 20'h00AB5, '0, '0, 0, "R6");   // write hit visible
    access(1'b1, 32'h0000_1012, 20'h00AB5, 32'h1122_3344, 4'b0101, 2, "R6");
    access(1'b0, 32'h0000_1010, 20'h00AB5, '0, '0, 0, "R6");   // merged bytes
    access(1'b1, 32'h0000_2040, 20'h00777, 32'hCAFE_F00D, 4'hF, 0, "R6");
    access(1'b0, 32'h0000_2040, 20'h00777, '0, '0, 0, "R6");   // no allocate: misses
    access(1'b0, 32'h0003_5010, 20'h00AB5, '0, '0, 0, "R7");   // synonym hits
    access(1'b0, 32'h0000_1010, 20'h00CC0, '0, '0, 0, "R7");   // remapped page misses
    access(1'b0, 32'h0000_1010, 20'h00AB5, '0, '0, 0, "R8");   // evicted frame misses
    idle_check();

    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      logic [19:0] pf;
      logic [3:0]  be;
      va = {12'($urandom_range(0, 3)), 8'h00, 2'($urandom_range(0, 3)),
            2'b00, 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      pf = 20'h00100 + 20'($urandom_range(0, 3));
      be = 4'($urandom_range(1, 15));
      access(1'($urandom_range(0, 2) == 0), va, pf, $urandom, be,
             $urandom_range(0, 2), "");
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0, "all expected reads completed");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule